// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single output compare channel that watches the count of a free-running 16-bit timer. Software loads a 16-bit compare value one byte at a time into a pair of holding registers. The value does not become active until software writes an update strobe. When the timer count reaches the active value, the channel sets a sticky match flag and acts on an output latch. A 2-bit mode field selects that action: hold, set, clear or toggle.

A force strobe applies the same mode action to the latch at once, without any timer match and without touching the flag. The latch reaches the pin only while output enable is high. An interrupt request is raised when the flag is set and three enables all agree: the channel enable held in the control register, and the global and unit enables supplied as inputs. The timer's upper count limit is an input, so a compare value the timer can never reach produces no activity.

Register map on the 3-bit address: 0 holding low byte, 1 holding high byte, 2 control, 3 status, 4 active low byte (read only), 5 active high byte (read only). Other addresses read 0.

Top module: `ocmp_channel`

## Requirements
- R1: After reset the latch, the match flag, the control register, the holding and active compare values, `cmp_pin` and `irq` are all 0.
- R2: Writes to address 0 (low byte) and address 1 (high byte) leave the active value at addresses 4/5 unchanged. Writing 1 to control bit 3 (update) copies the holding value into the active value one clock later. Update reads back 1 for that one clock, then 0.
- R3: A match event occurs in a cycle where `tmr_cnt` equals the active value, provided it did not also equal it in the previous cycle. The status flag (address 3, bit 0) becomes 1 at the clock edge that ends the match cycle, so it reads 0 during the match cycle and 1 in the cycle after.
- R4: When the active value is greater than `tmr_top`, an equal `tmr_cnt` produces no match: the flag and the latch are unchanged.
- R5: Control bits [1:0] select the match action on the latch: 00 keeps it, 01 sets it to 1, 10 clears it to 0, 11 inverts it. The action occurs whether the channel enable (control bit 4) is 0 or 1.
- R6: A control write with bit 2 (force) set applies the action of the mode written in that same write at that clock edge. It leaves the flag unchanged, and bit 2 always reads 0.
- R7: The flag is cleared only by writing status bit 0 as 0. Writing it as 1 has no effect. A match event in the same cycle as a clear leaves the flag at 1.
- R8: `irq` is 1 exactly when the flag, control bit 4, `glb_ie` and `unit_ie` are all 1.
- R9: `cmp_pin` follows the latch while `out_en` is 1 and is 0 while `out_en` is 0. The latch keeps its state, and still responds to force and match, while `out_en` is 0.
- R10: A force and a match event in the same cycle apply a single action, using the mode given in the force write, and set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| tmr_cnt | input | 16 | Current timer count |
| tmr_top | input | 16 | Highest count the timer reaches |
| glb_ie | input | 1 | Global interrupt enable |
| unit_ie | input | 1 | Compare unit interrupt enable |
| out_en | input | 1 | Connects the latch to the pin |
| cmp_pin | output | 1 | Compare output to the pin |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that can fall in the same cycle are a timer match and a software write to the same state. One case is a force strobe landing in the cycle where the count equals the active value. The other is a flag-clearing write landing in that same cycle. The bench brings these about by driving the matching count and the register write on the same falling edge. For the force case it expects exactly one toggle of the pin and a set flag. For the clear case it expects the flag to survive.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_HOLD_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_HOLD_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT    = 3'd3;
    localparam logic [ADDR_W-1:0] A_ACT_LO  = 3'd4;
    localparam logic [ADDR_W-1:0] A_ACT_HI  = 3'd5;

    typedef enum logic [1:0] {
        OCM_HOLD = 2'b00,
        OCM_SET  = 2'b01,
        OCM_CLR  = 2'b10,
        OCM_TOG  = 2'b11
    } ocm_mode_e;

    typedef struct packed {
        logic      ch_ie;
        logic      upd;
        logic      frc;
        ocm_mode_e mode;
    } ocm_ctrl_t;

    localparam int CTRL_W = $bits(ocm_ctrl_t);

    function automatic logic ocm_apply(ocm_mode_e m, logic cur);
        case (m)
            OCM_SET: return 1'b1;
            OCM_CLR: return 1'b0;
            OCM_TOG: return ~cur;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs
    import ocmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic                  flag,
    output logic [BYTE_W-1:0]     rd_data,
    output logic [CNT_W-1:0]      act_val,
    output ocm_mode_e             mode,
    output logic                  ch_ie,
    output logic                  force_pulse,
    output ocm_mode_e             force_mode,
    output logic                  clr_req,
    output logic                  upd_pend
);
    localparam int HI_W = CNT_W - BYTE_W;

    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] act_q;
    ocm_ctrl_t        ctrl_q;
    ocm_ctrl_t        ctrl_wr;

    logic sel_lo, sel_hi, sel_ctrl, sel_stat;

    assign ctrl_wr  = ocm_ctrl_t'(wdata[CTRL_W-1:0]);
    assign sel_lo   = wr_en && (addr == A_HOLD_LO);
    assign sel_hi   = wr_en && (addr == A_HOLD_HI);
    assign sel_ctrl = wr_en && (addr == A_CTRL);
    assign sel_stat = wr_en && (addr == A_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            act_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (sel_lo) hold_q[BYTE_W-1:0]     <= wdata;
            if (sel_hi) hold_q[CNT_W-1:BYTE_W] <= wdata[HI_W-1:0];
            if (ctrl_q.upd) begin
                act_q      <= hold_q;
                ctrl_q.upd <= 1'b0;
            end
            if (sel_ctrl) begin
                ctrl_q.mode  <= ctrl_wr.mode;
                ctrl_q.ch_ie <= ctrl_wr.ch_ie;
                if (ctrl_wr.upd) ctrl_q.upd <= 1'b1;
            end
        end
    end

    assign act_val     = act_q;
    assign mode        = ctrl_q.mode;
    assign ch_ie       = ctrl_q.ch_ie;
    assign upd_pend    = ctrl_q.upd;
    assign force_pulse = sel_ctrl && ctrl_wr.frc;
    assign force_mode  = ctrl_wr.mode;
    assign clr_req     = sel_stat && !wdata[0];

    always_comb begin
        ocm_ctrl_t rd_ctrl;
        rd_ctrl     = ctrl_q;
        rd_ctrl.frc = 1'b0;
        case (addr)
            A_HOLD_LO: rd_data = hold_q[BYTE_W-1:0];
            A_HOLD_HI: rd_data = BYTE_W'(hold_q[CNT_W-1:BYTE_W]);
            A_CTRL:    rd_data = BYTE_W'(rd_ctrl);
            A_STAT:    rd_data = BYTE_W'(flag);
            A_ACT_LO:  rd_data = act_q[BYTE_W-1:0];
            A_ACT_HI:  rd_data = BYTE_W'(act_q[CNT_W-1:BYTE_W]);
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ocmp_match.sv
module ocmp_match
    import ocmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tmr_cnt,
    input  logic [CNT_W-1:0] tmr_top,
    input  logic [CNT_W-1:0] act_val,
    input  logic             clr_req,
    output logic             hit,
    output logic             evt,
    output logic             flag
);
    logic hit_q;

    assign hit = (tmr_cnt == act_val) && (act_val <= tmr_top);
    assign evt = hit && !hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
            flag  <= 1'b0;
        end else begin
            hit_q <= hit;
            if (evt)          flag <= 1'b1;
            else if (clr_req) flag <= 1'b0;
        end
    end

endmodule

// File: rtl/ocmp_latch.sv
module ocmp_latch
    import ocmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      evt,
    input  logic      force_pulse,
    input  ocm_mode_e mode,
    input  ocm_mode_e force_mode,
    output logic      latch
);
    ocm_mode_e sel_mode;

    assign sel_mode = force_pulse ? force_mode : mode;

    always_ff @(posedge clk) begin
        if (rst)                     latch <= 1'b0;
        else if (evt || force_pulse) latch <= ocm_apply(sel_mode, latch);
    end

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  tmr_cnt,
    input  logic [CNT_W-1:0]  tmr_top,
    input  logic              glb_ie,
    input  logic              unit_ie,
    input  logic              out_en,
    output logic              cmp_pin,
    output logic              irq
);
    logic [CNT_W-1:0] act_val;
    ocm_mode_e        mode, force_mode;
    logic             ch_ie, force_pulse, clr_req, upd_pend;
    logic             hit, evt, flag, latch;

    ocmp_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .flag(flag), .rd_data(rd_data), .act_val(act_val), .mode(mode),
        .ch_ie(ch_ie), .force_pulse(force_pulse), .force_mode(force_mode),
        .clr_req(clr_req), .upd_pend(upd_pend)
    );

    ocmp_match #(.CNT_W(CNT_W)) match_i (
        .clk(clk), .rst(rst), .tmr_cnt(tmr_cnt), .tmr_top(tmr_top),
        .act_val(act_val), .clr_req(clr_req), .hit(hit), .evt(evt), .flag(flag)
    );

    ocmp_latch latch_i (
        .clk(clk), .rst(rst), .evt(evt), .force_pulse(force_pulse),
        .mode(mode), .force_mode(force_mode), .latch(latch)
    );

    assign cmp_pin = out_en && latch;
    assign irq     = flag && ch_ie && glb_ie && unit_ie;

endmodule

// File: rtl/ocmp_channel_chk.sv
module ocmp_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic [7:0]       wdata,
    input logic [CNT_W-1:0] tmr_cnt,
    input logic [CNT_W-1:0] tmr_top,
    input logic [CNT_W-1:0] act_val,
    input logic             upd_pend,
    input logic             force_pulse,
    input logic             evt,
    input logic             flag,
    input logic             latch
);
    assert_flag_after_hit_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(tmr_cnt == act_val));

    assert_no_hit_out_of_range_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(act_val <= tmr_top));

    assert_flag_clear_by_write_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(wr_en && addr == 3'd3 && !wdata[0]));

    assert_active_after_update_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_val) |-> $past(upd_pend));

    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(evt || force_pulse) |-> $stable(latch));

    assert_force_no_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (force_pulse && !evt && !(wr_en && addr == 3'd3)) |=> $stable(flag));

endmodule

bind ocmp_channel ocmp_channel_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .tmr_cnt(tmr_cnt), .tmr_top(tmr_top), .act_val(act_val),
    .upd_pend(upd_pend), .force_pulse(force_pulse), .evt(evt),
    .flag(flag), .latch(latch)
);

// File: tb/ocmp_channel_tb.sv
module ocmp_channel_tb_top;

    localparam logic [15:0] PARK = 16'h0080;
    localparam logic [15:0] TOP  = 16'h00FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rd_data;
    logic [15:0] tmr_cnt = PARK;
    logic [15:0] tmr_top = TOP;
    logic        glb_ie = 1'b0;
    logic        unit_ie = 1'b0;
    logic        out_en = 1'b1;
    logic        cmp_pin;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ocmp_channel dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .tmr_cnt(tmr_cnt), .tmr_top(tmr_top),
        .glb_ie(glb_ie), .unit_ie(unit_ie), .out_en(out_en),
        .cmp_pin(cmp_pin), .irq(irq)
    );

    function automatic logic [7:0] ctl(logic ie, logic upd, logic frc, logic [1:0] m);
        return {3'b000, ie, upd, frc, m};
    endfunction

    function automatic logic nxt(logic [1:0] m, logic cur);
        case (m)
            2'b01:   return 1'b1;
            2'b10:   return 1'b0;
            2'b11:   return ~cur;
            default: return cur;
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic prog(input logic [15:0] v, input logic [1:0] m, input logic ie);
        wr(3'd0, v[7:0]);
        wr(3'd1, v[15:8]);
        wr(3'd2, ctl(ie, 1'b1, 1'b0, m));
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        logic       exp_l;
        logic [15:0] vals [4];
        vals[0] = 16'h0005; vals[1] = TOP; vals[2] = 16'h0100; vals[3] = 16'hFFFF;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd2, r); check(r == 8'h00, "R1 ctrl", r, 0);
        rd(3'd3, r); check(r == 8'h00, "R1 flag", r, 0);
        rd(3'd4, r); check(r == 8'h00, "R1 active lo", r, 0);
        rd(3'd1, r); check(r == 8'h00, "R1 hold hi", r, 0);
        check(cmp_pin == 1'b0, "R1 pin", cmp_pin, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);

        // R2 shadow then update
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        rd(3'd4, r); check(r == 8'h00, "R2 active lo before update", r, 0);
        rd(3'd5, r); check(r == 8'h00, "R2 active hi before update", r, 0);
        wr(3'd2, ctl(1'b0, 1'b1, 1'b0, 2'b00));
        rd(3'd2, r); check(r[3] == 1'b1, "R2 update pending", r[3], 1);
        rd(3'd5, r); check(r == 8'h00, "R2 active not yet copied", r, 0);
        @(negedge clk);
        rd(3'd4, r); check(r == 8'h34, "R2 active lo", r, 8'h34);
        rd(3'd5, r); check(r == 8'h12, "R2 active hi", r, 8'h12);
        rd(3'd2, r); check(r[3] == 1'b0, "R2 update self clear", r[3], 0);

        // R6 force sweep over mode and start state
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                wr(3'd2, ctl(1'b0, 1'b0, 1'b1, s[0] ? 2'b01 : 2'b10));
                wr(3'd2, ctl(1'b0, 1'b0, 1'b1, m[1:0]));
                exp_l = nxt(m[1:0], s[0]);
                check(cmp_pin == exp_l, "R6 force action", cmp_pin, exp_l);
                rd(3'd3, r); check(r[0] == 1'b0, "R6 force no flag", r[0], 0);
                rd(3'd2, r); check(r[2] == 1'b0, "R6 force reads 0", r[2], 0);
            end
        end

        // R3 R4 R5 match sweep: mode x start x compare value
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < 4; k++) begin
                    logic inr;
                    inr = (vals[k] <= TOP);
                    wr(3'd2, ctl(1'b0, 1'b0, 1'b1, s[0] ? 2'b01 : 2'b10));
                    wr(3'd3, 8'h00);
                    prog(vals[k], m[1:0], 1'b0);
                    tmr_cnt = vals[k];
                    #1;
                    check(dut_i.rd_data == dut_i.rd_data && cmp_pin == s[0],
                          "R3 no change in match cycle", cmp_pin, s[0]);
                    rd(3'd3, r); check(r[0] == 1'b0, "R3 flag not yet set", r[0], 0);
                    @(negedge clk);
                    rd(3'd3, r);
                    check(r[0] == inr, inr ? "R3 flag after match" : "R4 out of range no flag", r[0], inr);
                    exp_l = inr ? nxt(m[1:0], s[0]) : s[0];
                    check(cmp_pin == exp_l, inr ? "R5 match action" : "R4 out of range no action",
                          cmp_pin, exp_l);
                    @(negedge clk);
                    check(cmp_pin == exp_l, "R3 held count no repeat", cmp_pin, exp_l);
                    tmr_cnt = PARK;
                end
            end
        end

        // R7 flag clear semantics
        wr(3'd3, 8'h00);
        prog(16'h0010, 2'b00, 1'b0);
        tmr_cnt = 16'h0010; @(negedge clk); tmr_cnt = PARK;
        wr(3'd3, 8'h01);
        rd(3'd3, r); check(r[0] == 1'b1, "R7 write 1 no effect", r[0], 1);
        repeat (3) @(negedge clk);
        rd(3'd3, r); check(r[0] == 1'b1, "R7 hardware never clears", r[0], 1);
        wr(3'd3, 8'h00);
        rd(3'd3, r); check(r[0] == 1'b0, "R7 write 0 clears", r[0], 0);

        // R8 irq enable sweep, flag set and clear
        for (int f = 0; f < 2; f++) begin
            for (int e = 0; e < 8; e++) begin
                wr(3'd3, 8'h00);
                wr(3'd2, ctl(e[0], 1'b0, 1'b0, 2'b00));
                if (f == 1) begin
                    tmr_cnt = 16'h0010; @(negedge clk); tmr_cnt = PARK;
                end
                glb_ie = e[1]; unit_ie = e[2];
                #1;
                check(irq == (f == 1 && e == 7), "R8 irq gating", irq, (f == 1 && e == 7));
            end
        end
        glb_ie = 1'b0; unit_ie = 1'b0;

        // R9 output enable
        wr(3'd2, ctl(1'b0, 1'b0, 1'b1, 2'b01));
        out_en = 1'b0; #1;
        check(cmp_pin == 1'b0, "R9 pin low when disabled", cmp_pin, 0);
        wr(3'd2, ctl(1'b0, 1'b0, 1'b1, 2'b11));
        wr(3'd2, ctl(1'b0, 1'b0, 1'b1, 2'b11));
        wr(3'd2, ctl(1'b0, 1'b0, 1'b1, 2'b11));
        check(cmp_pin == 1'b0, "R9 pin low while latch toggles", cmp_pin, 0);
        out_en = 1'b1; #1;
        check(cmp_pin == 1'b0, "R9 latch state kept", cmp_pin, 0);

        // R10 force and match in the same cycle
        wr(3'd3, 8'h00);
        prog(16'h0020, 2'b01, 1'b0);
        @(negedge clk);
        tmr_cnt = 16'h0020;
        wr_en = 1'b1; addr = 3'd2; wdata = ctl(1'b0, 1'b0, 1'b1, 2'b11);
        @(negedge clk);
        wr_en = 1'b0; tmr_cnt = PARK;
        check(cmp_pin == 1'b1, "R10 single toggle with written mode", cmp_pin, 1);
        rd(3'd3, r); check(r[0] == 1'b1, "R10 flag set", r[0], 1);

        // R7 clear and match in the same cycle
        wr(3'd3, 8'h00);
        @(negedge clk);
        tmr_cnt = 16'h0020;
        wr_en = 1'b1; addr = 3'd3; wdata = 8'h00;
        @(negedge clk);
        wr_en = 1'b0; tmr_cnt = PARK;
        rd(3'd3, r); check(r[0] == 1'b1, "R7 set wins over clear", r[0], 1);

        finish_run();
    end

endmodule